// File: doc/BRIEF.md
# Early-Exit Sequential Population Counter

This block counts the ones in a data word of parameterised width, 16 bits by default and 32 as an option. It does not use a wide adder tree. It uses one right-shifting register that fills with zeros, a one-bit capture flop for the bit that falls out, a small ones counter and a four-state one-hot controller. A start pulse in the idle state loads the word and presets the counter to all ones. The controller then alternates between shifting, an empty settling state and a counting state.

The loop ends as soon as the remaining contents of the shift register are all zero. The run time therefore follows the position of the highest set bit rather than the word width. The counter starts at all ones, so the unconditional first pass through the counting state wraps it to zero. After that, every captured one adds one. When the run is over, the block returns to idle, raises `done` and holds the count on `result` until the next start.

Top module: `popcount_seq`

## Requirements
- R1: After reset the controller has only its idle state bit set, `done` is low and `result` is 0.
- R2: A `start` pulse sampled high while idle loads `dataIn`. When `done` next rises, `result` equals the number of ones in that word. `result` is `$clog2(WIDTH+1)` bits wide.
- R3: A word of zero finishes one clock edge after the edge that sampled `start`, with `result` 0 and no shift performed.
- R4: Bit 0 is the least significant bit and the word shifts towards bit 0. Let h be the index of the highest set bit. A nonzero word finishes exactly 1 + 2*(h+1) + popcount clock edges after the edge that sampled `start`.
- R5: `done` is low from the edge that loads a word until the run finishes. It is high in idle after a run. `result` and `done` stay unchanged while idle with `start` low.
- R6: `start` asserted while a run is in progress has no effect on `result` or on the run length.
- R7: Two shifts never occur on consecutive cycles. A settling state always separates a shift from the test of the captured bit.
- R8: A load presets the ones counter to all ones. Each counting step adds exactly one, modulo the counter width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a count; sampled only while idle |
| dataIn | input | WIDTH | Word to count, captured on the start edge |
| result | output | $clog2(WIDTH+1) | Number of ones in the last loaded word |
| done | output | 1 | High in idle after a completed run |

## Verification
A wrong controller state or a lost shift shows up at the ports in two ways: `done` rises on the wrong edge, and `result` differs from the arithmetic popcount. The bench therefore measures the edge count of every run against 1 + 2*(h+1) + popcount, and compares the result with the popcount. A wrong counter preset or a missed increment appears on the very first run as a result that is off by a constant. A missed early exit or a skipped settling state changes the latency of every nonzero word. A start pulse injected in the middle of a run must leave both the latency and the result untouched.

// File: rtl/popcount_pkg.sv
package popcount_pkg;
  // One-hot state bit positions
  localparam int ST_IDLE   = 0;
  localparam int ST_COUNT  = 1;
  localparam int ST_SHIFT  = 2;
  localparam int ST_SETTLE = 3;
  localparam int NUM_ST    = 4;

  typedef struct packed {
    logic load;
    logic count;
    logic shift;
  } pcStrobe_t;
endpackage

// File: rtl/popcount_ctrl.sv
module popcount_ctrl
  import popcount_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      allZero,
  input  logic      eBit,
  output pcStrobe_t strb,
  output logic      done
);
  logic [NUM_ST-1:0] st, stNext;
  logic doneReg;

  always_comb begin
    stNext[ST_IDLE]   = (st[ST_IDLE] & ~start) | (st[ST_COUNT] & allZero);
    stNext[ST_COUNT]  = (st[ST_SETTLE] & eBit) | (st[ST_IDLE] & start);
    stNext[ST_SHIFT]  = (st[ST_COUNT] & ~allZero) | (st[ST_SETTLE] & ~eBit);
    stNext[ST_SETTLE] = st[ST_SHIFT];
  end

  always_comb begin
    strb.load  = st[ST_IDLE] & start;
    strb.count = st[ST_COUNT];
    strb.shift = st[ST_SHIFT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= NUM_ST'(1) << ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      st <= stNext;
      if (strb.load)
        doneReg <= 1'b0;
      else if (st[ST_COUNT] & allZero)
        doneReg <= 1'b1;
    end
  end

  assign done = doneReg;

  // R1
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(st) == 1);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> st[ST_IDLE]);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
endmodule

// File: rtl/popcount_dp.sv
module popcount_dp
  import popcount_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobe_t        strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic             allZero,
  output logic             eBit,
  output logic [CNT_W-1:0] cnt
);
  logic [WIDTH-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      eBit  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (strb.load) begin
        shReg <= dataIn;
        cnt   <= '1;
      end else begin
        if (strb.shift) begin
          shReg <= shReg >> 1;
          eBit  <= shReg[0];
        end
        if (strb.count)
          cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign allZero = ~|shReg;

  // R8
  load_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cnt == '1) && (shReg == $past(dataIn)));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.count |=> cnt == ($past(cnt) + CNT_W'(1)));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.count) |=> $stable(cnt));

  // R7
  shift_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> !strb.shift);

  // R7
  shift_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (shReg == ($past(shReg) >> 1)) && (eBit == $past(shReg[0])));
endmodule

// File: rtl/popcount_seq.sv
module popcount_seq
  import popcount_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic [CNT_W-1:0] result,
  output logic             done
);
  pcStrobe_t strb;
  logic allZero;
  logic eBit;

  popcount_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .allZero(allZero),
    .eBit(eBit), .strb(strb), .done(done)
  );

  popcount_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .allZero(allZero), .eBit(eBit), .cnt(result)
  );
endmodule

// File: tb/popcount_seq_test.sv
module popcount_seq_test;
  localparam int W  = 10;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [CW-1:0] result;
  logic done;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  popcount_seq #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
    .result(result), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runWord(input logic [W-1:0] w, input bit poke);
    int pop = 0;
    int hi = -1;
    int expL;
    int n = 0;
    bit fin = 0;
    logic [CW-1:0] held;
    for (int i = 0; i < W; i++) if (w[i]) begin pop++; hi = i; end
    expL = (w == '0) ? 1 : 1 + 2 * (hi + 1) + pop;
    @(negedge clk);
    start = 1'b1;
    dataIn = w;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    dataIn = ~w;
    check(done == 1'b0, "R5 done low after load", int'(done), 0);
    for (int k = 0; k < 200 && !fin; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (done) fin = 1;
      else if (poke && n == 2) start = 1'b1;  // R6 start mid-run
    end
    start = 1'b0;
    if (w == '0) begin
      check(int'(result) == 0, "R3 zero word result", int'(result), 0);
      check(n == 1, "R3 zero word latency", n, 1);
    end else begin
      check(int'(result) == pop, poke ? "R6 result with mid-run start" : "R2 popcount",
            int'(result), pop);
      check(n == expL, poke ? "R6 latency with mid-run start" : "R4 latency", n, expL);
    end
    held = result;
    repeat (3) @(negedge clk);
    check(result == held && done == 1'b1, "R5 idle hold", int'(result), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(result == '0, "R1 result after reset", int'(result), 0);
    // R3 zero word first
    runWord('0, 1'b0);
    // R8 all ones exercises full count and widest latency
    runWord('1, 1'b0);
    runWord(W'(1), 1'b0);
    runWord(W'(1) << (W - 1), 1'b1);
    // R2 R4 exhaustive sweep, R6 pokes on some words
    for (int v = 0; v < (1 << W); v++)
      runWord(W'(v), (v % 7 == 3));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule